// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of a successive-approximation converter. It holds an 8-bit control/status register and a 3-bit input-select register, both on a small register bus. It drives an abstract converter core through an enable level, a one-cycle start pulse and a busy level, and it listens for a done pulse from the core. Conversions run either one at a time, each started by software, or back to back once the first one has been started.

The input-select code is copied into a working latch only while no conversion is running. A code written in mid-conversion therefore reaches the analog front end only after that conversion finishes. The latched code is decoded into a one-hot positive-input select, a one-hot negative-input select and a high-gain flag. Each finished conversion sets a completion flag. An interrupt request is raised while the flag and the interrupt enable are both set.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset both registers read 0, and conv_en, conv_start, conv_busy and irq are 0. The control register layout, bit 7 down to 0, is: enable, start, free-run, done flag, irq enable, then three prescaler bits. The prescaler bits read back as written and drive presc.
- R2: With enable at 1, writing the start bit (bit 6) as 1 raises conv_start in the second clock after the write edge, and conv_busy rises with it. In single mode the start bit reads 0 after the done pulse, the flag (bit 4) reads 1, and no further start follows.
- R3: With free-run (bit 5) set, one start write produces a new conv_start two clocks after each done pulse, and the start bit stays at 1.
- R4: Writing 0 to the start bit has no effect. A running free-run sequence keeps going, and the bit still reads 1.
- R5: Clearing free-run mid-sequence lets the current conversion finish and set the flag. After that no conversion starts and the start bit reads 0.
- R6: Writing enable (bit 7) as 0 drops conv_busy and conv_en at the next edge and clears the start bit. A later done pulse from the core does not set the flag.
- R7: A start write while enable is written 0 is ignored. The start bit reads 0 and no conv_start occurs.
- R8: A write to the input-select register during a conversion reads back at once. pos_sel, neg_sel and gain_hi keep the value latched at conv_start until the conversion completes. They take the new code one clock after busy falls.
- R9: The decode follows the code. Codes 0 to 3 give pos_sel one-hot at that input, neg_sel 0 and gain_hi 0. Codes 4 and 5 give input 2 on both sides. Codes 6 and 7 give input 2 positive and input 3 negative. In each of these two pairs the odd code sets gain_hi.
- R10: Bits 7 to 3 of the input-select register always read 0.
- R11: Writing 1 to the flag bit clears it, and writing 0 leaves it unchanged. A done pulse in the same cycle as a clearing write leaves the flag set.
- R12: irq is 1 exactly while the flag and the irq-enable bit (bit 3) are both 1.
- R13: conv_start is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (control at CTL_ADDR, input-select at CHAN_ADDR) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| conv_en | output | 1 | Converter power/enable level |
| conv_start | output | 1 | One-cycle start pulse to the core |
| conv_busy | output | 1 | A conversion is in flight |
| conv_done | input | 1 | Completion pulse from the core |
| presc | output | 3 | Prescaler select field |
| pos_sel | output | 4 | One-hot positive input select |
| neg_sel | output | 4 | One-hot negative input select, 0 for single-ended |
| gain_hi | output | 1 | High-gain (20x) select |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 1-bit address, a 3-bit select code and four inputs. All eight select codes are swept, and each decode is computed arithmetically. Both sequencing modes are driven by a converter model with a programmable latency. Individual cycles are hand-timed to bring the corner cases within reach: an abort mid-conversion, a select write mid-conversion, and a flag-clear write colliding with a done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CTL_W  = 8;
    localparam int PS_W   = 3;
    localparam int CODE_W = 3;
    localparam int IDX_W  = CODE_W - 1;
    localparam int NUM_IN = 2 ** IDX_W;

    // field order is the register layout, msb first
    typedef struct packed {
        logic            en;
        logic            sc;
        logic            fr;
        logic            flag;
        logic            ie;
        logic [PS_W-1:0] ps;
    } ctl_t;

    typedef struct packed {
        ctl_t              ctl;
        logic [CODE_W-1:0] chan;
        logic [CODE_W-1:0] lat;
        logic              busy;
        logic              start;
    } seq_t;
endpackage

// File: rtl/adc_chan_decode.sv
module adc_chan_decode
    import adc_seq_pkg::*;
#(
    parameter int DIFF_POS = 2,
    parameter int DIFF_NEG = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [NUM_IN-1:0] pos_sel,
    output logic [NUM_IN-1:0] neg_sel,
    output logic              gain_hi
);
    logic             diff;
    logic [IDX_W-1:0] idx;

    assign diff    = code[CODE_W-1];
    assign idx     = code[IDX_W-1:0];
    assign gain_hi = diff && code[0];

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        assign pos_sel[i] = diff ? (i == DIFF_POS) : (idx == IDX_W'(i));
        assign neg_sel[i] = diff && (idx[IDX_W-1] ? (i == DIFF_NEG) : (i == DIFF_POS));
    end
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int CTL_ADDR  = 0,
    parameter int CHAN_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTL_W-1:0]  bus_wdata,
    output logic [CTL_W-1:0]  bus_rdata,
    output logic              conv_en,
    output logic              conv_start,
    output logic              conv_busy,
    input  logic              conv_done,
    output logic [PS_W-1:0]   presc,
    output logic [NUM_IN-1:0] pos_sel,
    output logic [NUM_IN-1:0] neg_sel,
    output logic              gain_hi,
    output logic              irq
);
    seq_t q, d;
    ctl_t wctl;
    logic wr_ctl, wr_chan, en_n, done_hit;

    always_comb begin
        d       = q;
        wctl    = ctl_t'(bus_wdata);
        wr_ctl  = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));
        wr_chan = bus_wr && (bus_addr == ADDR_W'(CHAN_ADDR));
        en_n    = wr_ctl ? wctl.en : q.ctl.en;
        // a done pulse counts only for a live, still-enabled conversion
        done_hit = q.busy && conv_done && en_n;

        d.start = 1'b0;

        if (wr_ctl) begin
            d.ctl.en = wctl.en;
            d.ctl.fr = wctl.fr;
            d.ctl.ie = wctl.ie;
            d.ctl.ps = wctl.ps;
            if (wctl.sc)   d.ctl.sc   = 1'b1;   // writing 0 does nothing
            if (wctl.flag) d.ctl.flag = 1'b0;   // write-1-to-clear
        end
        if (wr_chan) d.chan = bus_wdata[CODE_W-1:0];

        if (done_hit) begin
            d.busy     = 1'b0;
            d.ctl.flag = 1'b1;                  // set beats clear
            if (!d.ctl.fr) d.ctl.sc = 1'b0;
        end

        if (!en_n) begin
            d.ctl.sc = 1'b0;
            d.busy   = 1'b0;
        end

        // selection follows the register only between conversions
        if (!q.busy) d.lat = q.chan;

        if (en_n && q.ctl.sc && d.ctl.sc && !q.busy) begin
            d.start = 1'b1;
            d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (bus_addr == ADDR_W'(CHAN_ADDR)) bus_rdata = {(CTL_W-CODE_W)'(0), q.chan};
        else                                bus_rdata = CTL_W'(q.ctl);
    end

    assign conv_en    = q.ctl.en;
    assign conv_start = q.start;
    assign conv_busy  = q.busy;
    assign presc      = q.ctl.ps;
    assign irq        = q.ctl.flag && q.ctl.ie;

    adc_chan_decode u_dec (
        .code    (q.lat),
        .pos_sel (pos_sel),
        .neg_sel (neg_sel),
        .gain_hi (gain_hi)
    );
endmodule

// File: rtl/adc_ctrl_seq_chk.sv
module adc_ctrl_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W   = 1,
    parameter int CTL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en_bit,
    input logic              conv_en,
    input logic              conv_start,
    input logic              conv_busy,
    input logic              conv_done,
    input logic [NUM_IN-1:0] pos_sel,
    input logic [NUM_IN-1:0] neg_sel,
    input logic              gain_hi,
    input logic              irq
);
    // R13
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_busy && conv_en));

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !conv_start) |-> ($stable(pos_sel) && $stable(neg_sel) && $stable(gain_hi)));

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CTL_ADDR) && !wr_en_bit) |=> (!conv_busy && !conv_en));

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_done || bus_wr));

    // R9
    pos_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos_sel) == 1);
endmodule

bind adc_ctrl_seq adc_ctrl_seq_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wr_en_bit  (bus_wdata[7]),
    .conv_en    (conv_en),
    .conv_start (conv_start),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .pos_sel    (pos_sel),
    .neg_sel    (neg_sel),
    .gain_hi    (gain_hi),
    .irq        (irq)
);

// File: tb/adc_ctrl_seq_test.sv
module adc_ctrl_seq_test;
    localparam logic CTL  = 1'b0;
    localparam logic CHAN = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [0:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_en, conv_start, conv_busy;
    logic       conv_done = 1'b0;
    logic [2:0] presc;
    logic [3:0] pos_sel, neg_sel;
    logic       gain_hi, irq;

    int   checks = 0;
    int   errors = 0;
    int   nstart = 0;
    int   lat = 5;
    logic model_on = 1'b0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    adc_ctrl_seq uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_en(conv_en),
        .conv_start(conv_start), .conv_busy(conv_busy), .conv_done(conv_done),
        .presc(presc), .pos_sel(pos_sel), .neg_sel(neg_sel),
        .gain_hi(gain_hi), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start counter
    initial forever begin
        @(negedge clk);
        if (conv_start) nstart++;
    end

    // converter model
    initial forever begin
        @(negedge clk);
        if (model_on && conv_start) begin
            repeat (lat - 1) @(negedge clk);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTL, rv);  chk("R1 ctl reset", rv, 8'h00);
        rd(CHAN, rv); chk("R1 chan reset", rv, 8'h00);
        chk("R1 outputs reset", {conv_en, conv_start, conv_busy, irq}, 4'b0000);

        // R1 prescaler field
        wr(CTL, 8'h87); rd(CTL, rv);
        chk("R1 ps readback", rv, 8'h87); chk("R1 presc out", presc, 3'd7);
        wr(CTL, 8'h05); rd(CTL, rv);
        chk("R1 ps readback 2", rv, 8'h05); chk("R1 presc out 2", presc, 3'd5);
        wr(CTL, 8'h00);

        // R9 / R10 sweep of every select code
        for (int c = 0; c < 8; c++) begin
            logic [3:0] ep, en;
            logic       eg;
            wr(CHAN, 8'hF8 | 8'(c));
            idle(1);
            rd(CHAN, rv);
            chk("R10 chan readback", rv, 8'(c));
            ep = (c < 4) ? 4'(1 << c) : 4'b0100;
            en = (c < 4) ? 4'b0000 : ((c >= 6) ? 4'b1000 : 4'b0100);
            eg = (c >= 4) && (c % 2 == 1);
            chk("R9 pos_sel", pos_sel, ep);
            chk("R9 neg_sel", neg_sel, en);
            chk("R9 gain_hi", gain_hi, eg);
        end
        wr(CHAN, 8'h00);

        // R7 start ignored while disabled
        n0 = nstart;
        wr(CTL, 8'h40); rd(CTL, rv);
        chk("R7 start bit", rv, 8'h00);
        idle(5);
        chk("R7 no start", nstart - n0, 0);
        chk("R7 conv_en", conv_en, 1'b0);

        // R2 single conversion
        model_on = 1'b1; lat = 5;
        wr(CTL, 8'h88);
        n0 = nstart;
        wr(CTL, 8'hC8);
        @(negedge clk);
        chk("R2 start timing", conv_start, 1'b1);
        chk("R2 busy", conv_busy, 1'b1);
        @(negedge clk);
        chk("R13 pulse width", conv_start, 1'b0);
        idle(12);
        rd(CTL, rv);
        chk("R2 sc clear flag set", rv, 8'h98);
        chk("R2 one start", nstart - n0, 1);
        chk("R12 irq on", irq, 1'b1);

        // R11 / R12 flag handling
        wr(CTL, 8'h88); rd(CTL, rv);
        chk("R11 write 0 keeps flag", rv, 8'h98);
        wr(CTL, 8'h80); rd(CTL, rv);
        chk("R11 flag still set", rv, 8'h90);
        chk("R12 irq masked", irq, 1'b0);
        wr(CTL, 8'h98); rd(CTL, rv);
        chk("R11 flag cleared", rv, 8'h88);
        chk("R12 irq off", irq, 1'b0);

        // R3 free running
        n0 = nstart;
        wr(CTL, 8'hE0);
        idle(60);
        chk("R3 repeat count", (nstart - n0 >= 9) && (nstart - n0 <= 11), 1);
        rd(CTL, rv);
        chk("R3 sc stays", rv[6], 1'b1);

        // R4 writing 0 to start
        wr(CTL, 8'hA0);
        n0 = nstart;
        rd(CTL, rv);
        chk("R4 sc still 1", rv[6], 1'b1);
        idle(20);
        chk("R4 continues", nstart - n0 >= 2, 1);

        // R5 leave free running
        wr(CTL, 8'h80);
        idle(20);
        n0 = nstart;
        idle(20);
        chk("R5 no new start", nstart - n0, 0);
        rd(CTL, rv);
        chk("R5 final state", rv, 8'h90);

        // R6 abort
        wr(CTL, 8'h90);
        lat = 20;
        wr(CTL, 8'hC0);
        @(negedge clk);
        idle(3);
        chk("R6 running", conv_busy, 1'b1);
        wr(CTL, 8'h00);
        chk("R6 busy dropped", conv_busy, 1'b0);
        chk("R6 en dropped", conv_en, 1'b0);
        idle(30);
        rd(CTL, rv);
        chk("R6 no flag after abort", rv, 8'h00);

        // R8 select change mid conversion
        lat = 10;
        wr(CTL, 8'h80);
        wr(CHAN, 8'h00);
        wr(CTL, 8'hC0);
        @(negedge clk);
        chk("R8 started", conv_start, 1'b1);
        wr(CHAN, 8'h07);
        rd(CHAN, rv);
        chk("R8 readback new", rv, 8'h07);
        chk("R8 pos held", pos_sel, 4'b0001);
        chk("R8 gain held", gain_hi, 1'b0);
        while (conv_busy) @(negedge clk);
        @(negedge clk);
        chk("R8 pos updated", pos_sel, 4'b0100);
        chk("R8 neg updated", neg_sel, 4'b1000);
        chk("R8 gain updated", gain_hi, 1'b1);

        // R11 done colliding with clear
        model_on = 1'b0;
        idle(12);
        wr(CTL, 8'h90);
        wr(CTL, 8'hC0);
        idle(3);
        chk("R11 busy before collision", conv_busy, 1'b1);
        conv_done = 1'b1;
        bus_wr = 1'b1; bus_addr = CTL; bus_wdata = 8'h90;
        @(negedge clk);
        conv_done = 1'b0; bus_wr = 1'b0;
        rd(CTL, rv);
        chk("R11 set beats clear", rv, 8'h90);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule